// File: doc/BRIEF.md
# Hardware-limit timer control

This block is an up-counter whose running, clearing and halting are governed by one external control signal and by a programmable period. Software supplies a control byte, a period value, a one-shot flag and writes an enable bit. The external signal is brought into the timer clock domain through a two-flop synchronizer, optionally inverted, and then examined for its level, its rising edge and its falling edge. Each of the three actions (begin counting, clear the counter, halt the counter) picks its own trigger: an edge, a level, or the moment the counter equals the active period.

When counting halts, the count is copied into a capture register. In one-shot mode a halt also drops the enable bit. The active period is a buffered copy of the period input. It is refreshed whenever the counter is cleared or halted, and continuously while the timer is disabled, so a new period written mid-run takes effect only at the next clear or halt.

Top module: `hlt_timer`

## Requirements
- R1: After synchronous reset, count_o, capture_o, run_o, match_o and on_o are all 0.
- R2: The begin mode is ctrl_i[5:4]: 00 runs whenever enabled, 01 begins on either external edge, 10 on the rising edge, 11 runs only while the external level is high. Edge and level triggers act only while on_o is 1. The counter advances by one per clock while run_o is 1.
- R3: ctrl_i[7]=1 inverts the synchronized external signal before any level or edge test.
- R4: For clear modes ctrl_i[3:2] of 01, 10 and 11, a running counter equal to the active period becomes 0 on the next clock.
- R5: With clear mode 01, while the (polarity-adjusted) external level is low and the timer is enabled, the counter is held at 0 and run_o is held at 0.
- R6: With clear mode 10, every begin trigger of an edge-type begin mode zeroes the counter, including one that arrives while already running. For level-type begin modes, only the idle-to-running transition zeroes it.
- R7: A begin trigger that arrives while running does not restart or otherwise alter the run state.
- R8: Halt mode ctrl_i[1:0] 11 halts at period match, 10 on the rising edge and 01 on either edge. A halt clears run_o, copies the count to capture_o and freezes the count. capture_o only ever takes the count of the previous cycle.
- R9: With halt mode 00 nothing halts the timer, and capture_o takes the count on every rising external edge while enabled.
- R10: With oneshot_i=1, a halt clears on_o on the same clock.
- R11: Writing 0 to the enable (on_wr_i=1, on_wdata_i=0) drops on_o on the next clock. The counter advances at most once more, run_o is 0 from the following clock, and the count then holds.
- R12: The active period is reloaded from period_i while disabled and on every clear or halt. A change of period_i during a run is not seen before that.
- R13: match_o is 1 in exactly those cycles where run_o is 1, the timer is enabled and count_o equals the active period.
- R14: An external edge driven just before clock edge k takes effect at clock edge k+2, and enabling takes effect three clock edges after the enable register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| on_wr_i | input | 1 | Strobe that writes the enable bit |
| on_wdata_i | input | 1 | Enable value written on the strobe |
| ers_i | input | 1 | Asynchronous external control signal |
| oneshot_i | input | 1 | Clear the enable on a halt |
| ctrl_i | input | 8 | [7] polarity, [6] sync select (always synchronized), [5:4] begin, [3:2] clear, [1:0] halt |
| period_i | input | CNT_W | Period value to be buffered |
| count_o | output | CNT_W | Counter value |
| capture_o | output | CNT_W | Captured counter value |
| run_o | output | 1 | Counter running |
| match_o | output | 1 | Running counter equals active period |
| on_o | output | 1 | Enable state |

## Verification
The hardest situation to reach is a begin trigger that lands while the counter is already running, with clear mode 10 selected. That trigger must zero the counter yet leave the run state untouched, and the zeroing has to be told apart from ordinary counting. The stimulus drives the external signal on falling clock edges and counts every clock through the two synchronizer stages and the edge register. It toggles the signal at a known count, so the expected post-trigger value differs sharply from the value an uncleared counter would reach. The same edge-accurate driving is used to show that a second rising edge halts the timer instead of restarting it.

// File: rtl/hlt_pkg.sv
package hlt_pkg;

  typedef enum logic [1:0] {
    BEG_ENABLED = 2'b00,
    BEG_ANY     = 2'b01,
    BEG_RISE    = 2'b10,
    BEG_HIGH    = 2'b11
  } beg_mode_e;

  typedef enum logic [1:0] {
    CLR_NONE  = 2'b00,
    CLR_LOW   = 2'b01,
    CLR_BEGIN = 2'b10,
    CLR_MATCH = 2'b11
  } clr_mode_e;

  typedef enum logic [1:0] {
    HLT_NONE  = 2'b00,
    HLT_ANY   = 2'b01,
    HLT_RISE  = 2'b10,
    HLT_MATCH = 2'b11
  } hlt_mode_e;

  localparam int SYNC_DEPTH = 2;

endpackage

// File: rtl/hlt_sync.sv
module hlt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= '0;
      else     stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hlt_edge.sv
module hlt_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  input  logic inv_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;
  logic prev_v;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  // polarity applied to both samples so a polarity change alone is no edge
  assign lvl_o  = sig_i ^ inv_i;
  assign prev_v = prev_q ^ inv_i;
  assign rise_o = lvl_o & ~prev_v;
  assign fall_o = ~lvl_o & prev_v;
endmodule

// File: rtl/hlt_decide.sv
module hlt_decide
  import hlt_pkg::*;
(
  input  beg_mode_e beg_m,
  input  clr_mode_e clr_m,
  input  hlt_mode_e hlt_m,
  input  logic      active_i,
  input  logic      lvl_i,
  input  logic      rise_i,
  input  logic      fall_i,
  input  logic      run_i,
  input  logic      match_i,
  output logic      run_nxt_o,
  output logic      halt_o,
  output logic      cap_o,
  output logic      lvl_clr_o,
  output logic      beg_clr_o,
  output logic      match_clr_o
);
  logic beg_trig;
  logic hlt_trig;
  logic beg_edge_kind;

  always_comb begin
    unique case (beg_m)
      BEG_ENABLED: beg_trig = 1'b1;
      BEG_ANY:     beg_trig = rise_i | fall_i;
      BEG_RISE:    beg_trig = rise_i;
      default:     beg_trig = lvl_i;
    endcase
  end

  always_comb begin
    unique case (hlt_m)
      HLT_MATCH: hlt_trig = match_i;
      HLT_RISE:  hlt_trig = rise_i;
      HLT_ANY:   hlt_trig = rise_i | fall_i;
      default:   hlt_trig = 1'b0;
    endcase
  end

  assign beg_edge_kind = (beg_m == BEG_ANY) || (beg_m == BEG_RISE);
  assign lvl_clr_o     = active_i && (clr_m == CLR_LOW) && !lvl_i;
  assign halt_o        = active_i && run_i && hlt_trig;
  assign match_clr_o   = (clr_m != CLR_NONE) && match_i;
  assign beg_clr_o     = active_i && (clr_m == CLR_BEGIN) && beg_trig
                         && (beg_edge_kind || !run_i);
  assign cap_o         = halt_o
                         || (active_i && (hlt_m == HLT_NONE) && rise_i);

  always_comb begin
    if (!active_i || lvl_clr_o)   run_nxt_o = 1'b0;
    else if (run_i)               run_nxt_o = !halt_o
                                              && ((beg_m != BEG_HIGH) || lvl_i);
    else                          run_nxt_o = beg_trig;
  end
endmodule

// File: rtl/hlt_count.sv
module hlt_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             run_nxt_i,
  input  logic             halt_i,
  input  logic             cap_i,
  input  logic             lvl_clr_i,
  input  logic             beg_clr_i,
  input  logic             match_clr_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capture_o,
  output logic [CNT_W-1:0] per_act_o,
  output logic             run_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] per_q;
  logic             run_q;
  logic             zero;
  logic             reload;

  assign zero   = lvl_clr_i || beg_clr_i || match_clr_i;
  assign reload = !active_i || zero || halt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cap_q <= '0;
      per_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_nxt_i;
      if (cap_i)  cap_q <= cnt_q;
      if (reload) per_q <= period_i;
      if (zero)
        cnt_q <= '0;
      else if (active_i && run_q && !halt_i)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o   = cnt_q;
  assign capture_o = cap_q;
  assign per_act_o = per_q;
  assign run_o     = run_q;
endmodule

// File: rtl/hlt_timer.sv
module hlt_timer
  import hlt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on_wr_i,
  input  logic             on_wdata_i,
  input  logic             ers_i,
  input  logic             oneshot_i,
  input  logic [7:0]       ctrl_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             run_o,
  output logic             match_o,
  output logic             on_o
);
  logic             on_q;
  logic             on_s;
  logic             ers_s;
  logic             active;
  logic             lvl, rise, fall;
  logic             run_nxt, halt, cap, lvl_clr, beg_clr, match_clr;
  logic             match;
  logic [CNT_W-1:0] per_act;
  logic             sync_sel_unused;

  // only the synchronized path exists; the select bit is kept for layout
  assign sync_sel_unused = ctrl_i[6];

  hlt_sync #(.W(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({on_q, ers_i}),
    .q_o ({on_s, ers_s})
  );

  assign active = on_s & on_q;

  hlt_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (ers_s),
    .inv_i  (ctrl_i[7]),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign match = active && run_o && (count_o == per_act);

  hlt_decide u_decide (
    .beg_m       (beg_mode_e'(ctrl_i[5:4])),
    .clr_m       (clr_mode_e'(ctrl_i[3:2])),
    .hlt_m       (hlt_mode_e'(ctrl_i[1:0])),
    .active_i    (active),
    .lvl_i       (lvl),
    .rise_i      (rise),
    .fall_i      (fall),
    .run_i       (run_o),
    .match_i     (match),
    .run_nxt_o   (run_nxt),
    .halt_o      (halt),
    .cap_o       (cap),
    .lvl_clr_o   (lvl_clr),
    .beg_clr_o   (beg_clr),
    .match_clr_o (match_clr)
  );

  hlt_count #(.CNT_W(CNT_W)) u_count (
    .clk         (clk),
    .rst         (rst),
    .active_i    (active),
    .run_nxt_i   (run_nxt),
    .halt_i      (halt),
    .cap_i       (cap),
    .lvl_clr_i   (lvl_clr),
    .beg_clr_i   (beg_clr),
    .match_clr_i (match_clr),
    .period_i    (period_i),
    .count_o     (count_o),
    .capture_o   (capture_o),
    .per_act_o   (per_act),
    .run_o       (run_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                    on_q <= 1'b0;
    else if (on_wr_i)           on_q <= on_wdata_i;
    else if (oneshot_i && halt) on_q <= 1'b0;
  end

  assign match_o = match;
  assign on_o    = on_q;
endmodule

// File: rtl/hlt_timer_chk.sv
module hlt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             on_wr_i,
  input logic             oneshot_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] capture_o,
  input logic             run_o,
  input logic             match_o,
  input logic             on_o
);
  p_cap_src_r8: assert property (@(posedge clk) disable iff (rst)
    (capture_o != $past(capture_o)) |-> (capture_o == $past(count_o)));

  p_match_run_r13: assert property (@(posedge clk) disable iff (rst)
    match_o |-> run_o);

  p_oneshot_off_r10: assert property (@(posedge clk) disable iff (rst)
    ($fell(on_o) && !$past(on_wr_i)) |-> ($past(oneshot_i) && !run_o));

  p_off_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!on_o && !$past(on_o)) |-> ($stable(count_o) && !run_o));

  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(run_o) && run_o) |->
      ((count_o == $past(count_o) + 1'b1) || (count_o == '0)
       || (count_o == $past(count_o))));
endmodule

bind hlt_timer hlt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .on_wr_i   (on_wr_i),
  .oneshot_i (oneshot_i),
  .count_o   (count_o),
  .capture_o (capture_o),
  .run_o     (run_o),
  .match_o   (match_o),
  .on_o      (on_o)
);

// File: tb/hlt_timer_bench.sv
`timescale 1ns/1ps
module hlt_timer_bench;
  localparam int CNT_W = 8;
  localparam int NV    = 9;

  // {ctrl, period, oneshot, ers, exp_count, exp_run, exp_capture, exp_on}
  localparam logic [63:0] VEC [NV] = '{
    {8'h40, 8'd200, 8'd0, 8'd0, 8'd10, 8'd1, 8'd0, 8'd1},
    {8'h4C, 8'd5,   8'd0, 8'd0, 8'd4,  8'd1, 8'd0, 8'd1},
    {8'h43, 8'd5,   8'd1, 8'd0, 8'd5,  8'd0, 8'd5, 8'd0},
    {8'h4F, 8'd5,   8'd0, 8'd0, 8'd3,  8'd1, 8'd5, 8'd1},
    {8'h70, 8'd200, 8'd0, 8'd0, 8'd0,  8'd0, 8'd0, 8'd1},
    {8'hF0, 8'd200, 8'd0, 8'd0, 8'd10, 8'd1, 8'd0, 8'd1},
    {8'h44, 8'd200, 8'd0, 8'd0, 8'd0,  8'd0, 8'd0, 8'd1},
    {8'h44, 8'd200, 8'd0, 8'd1, 8'd10, 8'd1, 8'd0, 8'd1},
    {8'hF0, 8'd200, 8'd0, 8'd1, 8'd0,  8'd0, 8'd0, 8'd1}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             on_wr = 1'b0;
  logic             on_wdata = 1'b0;
  logic             ers = 1'b0;
  logic             oneshot = 1'b0;
  logic [7:0]       ctrl = 8'h40;
  logic [CNT_W-1:0] period = '0;
  logic [CNT_W-1:0] count, capture;
  logic             run, match, on;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  hlt_timer #(.CNT_W(CNT_W)) u_hlt_timer (
    .clk        (clk),
    .rst        (rst),
    .on_wr_i    (on_wr),
    .on_wdata_i (on_wdata),
    .ers_i      (ers),
    .oneshot_i  (oneshot),
    .ctrl_i     (ctrl),
    .period_i   (period),
    .count_o    (count),
    .capture_o  (capture),
    .run_o      (run),
    .match_o    (match),
    .on_o       (on)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic restart(input logic [7:0] c, input logic [7:0] p,
                         input logic os, input logic e);
    rst = 1'b1; ctrl = c; period = p; oneshot = os; ers = e;
    on_wr = 1'b0;
    step(3);
    rst = 1'b0;
    step(4);
  endtask

  task automatic write_on(input logic v);
    on_wr = 1'b1; on_wdata = v;
    step(1);
    on_wr = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 capture", capture, 0);
    chk("R1 run", run, 0);
    chk("R1 match", match, 0);
    chk("R1 on", on, 0);

    // vector table: enable, then 14 clock edges in total (R2 R3 R4 R5 R8 R10 R14)
    for (int i = 0; i < NV; i++) begin
      restart(VEC[i][63:56], VEC[i][55:48], VEC[i][40], VEC[i][32]);
      write_on(1'b1);
      step(13);
      chk($sformatf("R2/R14 vec%0d count", i), count, VEC[i][31:24]);
      chk($sformatf("R3/R5 vec%0d run", i), run, VEC[i][16]);
      chk($sformatf("R8 vec%0d capture", i), capture, VEC[i][15:8]);
      chk($sformatf("R10 vec%0d on", i), on, VEC[i][0]);
    end

    // R2: external edges do nothing while disabled
    restart(8'h60, 8'd250, 1'b0, 1'b0);
    ers = 1'b1; step(6);
    chk("R2 disabled run", run, 0);
    chk("R2 disabled count", count, 0);

    // R7 R8 R14: rising begin, rising halt; second rise halts, not restarts
    restart(8'h62, 8'd250, 1'b0, 1'b0);
    write_on(1'b1); step(5);
    ers = 1'b1; step(6);
    chk("R14 rise begin count", count, 3);
    chk("R2 rise begin run", run, 1);
    ers = 1'b0; step(6);
    chk("R8 fall ignored count", count, 9);
    ers = 1'b1; step(5);
    chk("R8 halt count frozen", count, 11);
    chk("R8 halt capture", capture, 11);
    chk("R7 second rise no restart", run, 0);
    step(5);
    chk("R7 stays halted", run, 0);

    // R6 R9: either-edge begin with clear-on-begin, capture on rising edge
    restart(8'h58, 8'd250, 1'b0, 1'b0);
    write_on(1'b1); step(5);
    ers = 1'b1; step(10);
    chk("R6 first begin count", count, 7);
    ers = 1'b0; step(4);
    chk("R6 ignored begin still clears", count, 1);
    chk("R7 run kept", run, 1);
    ers = 1'b1; step(5);
    chk("R9 capture on rise", capture, 3);
    chk("R6 cleared again", count, 2);
    chk("R9 no halt", run, 1);

    // R5: level clear while running, then resume
    restart(8'h44, 8'd200, 1'b0, 1'b1);
    write_on(1'b1); step(13);
    ers = 1'b0; step(4);
    chk("R5 low clears count", count, 0);
    chk("R5 low holds run", run, 0);
    ers = 1'b1; step(6);
    chk("R5 resume count", count, 3);

    // R11: software disable
    begin
      int c0;
      c0 = count;
      write_on(1'b0);
      chk("R11 on drops", on, 0);
      step(2);
      chk("R11 count after disable", count, c0 + 1);
      chk("R11 run after disable", run, 0);
    end

    // R13 R4: match pulse and clear at match
    restart(8'h4C, 8'd3, 1'b0, 1'b0);
    write_on(1'b1); step(6);
    chk("R13 count at period", count, 3);
    chk("R13 match high", match, 1);
    step(1);
    chk("R4 cleared after match", count, 0);
    chk("R13 match low", match, 0);

    // R12: period change mid-run waits for next clear
    restart(8'h4C, 8'd5, 1'b0, 1'b0);
    write_on(1'b1); step(5);
    period = 8'd2; step(3);
    chk("R12 old period still active", count, 5);
    chk("R12 match on old period", match, 1);
    step(2);
    chk("R12 new period after clear", count, 1);
    step(2);
    chk("R12 new period wraps", count, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule